// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a reduced boundary-scan test access port. It uses the four-wire serial interface: a test clock, a mode select, serial data in and serial data out. There is no separate test reset pin. A 16-state controller, stepped by the mode select on each rising test clock, selects which register sits between serial in and serial out. The available registers are a 3-bit instruction register, a single-bit bypass path, and a boundary register that spans a parameterized number of pad cells.

Three operations are decoded. Bypass is the default. Sample/preload snapshots the pads while the core keeps control of them. External test hands the pads to the boundary register's update latches.

The block sits between the core and the pads. It merges a chip-wide high-impedance request into the pad enables. That request is ignored while external test is the active instruction. A power-on reset input puts the controller in its reset state at power-up. After that, the serial interface alone controls the block.

The scan path is a synchronous serial stream. It has no valid/ready handshake and no back-pressure: one bit moves on every test clock spent in a shift state, and every other port is a plain level.

Top module: `scan_tap_ctrl`

## Requirements
- R1: Power-on reset places the controller in Test-Logic-Reset. From any state, five test clocks with the mode select high also reach Test-Logic-Reset. In that state the current instruction is set to bypass.
- R2: The controller follows the standard 16-state boundary-scan graph. It moves on each rising test clock according to the mode select.
- R3: The instruction register is 3 bits wide and shifts out LSB first. In Capture-IR it loads the pattern 001, so the first three bits shifted out are 1, 0, 0.
- R4: Instruction codes are: 000 external test, 001 sample/preload, 111 bypass. Every other code behaves as bypass. A new instruction takes effect only in Update-IR.
- R5: With bypass active, Shift-DR passes serial in to serial out through one flop. That flop is cleared in Capture-DR, so the first bit out is 0.
- R6: With sample/preload or external test active, Capture-DR loads the boundary register, and the register shifts LSB first. Bits [N-1:0] take the pad inputs, bits [2N-1:N] take the core outputs, and bits [3N-1:2N] take the core output enables.
- R7: The update latches change only in Update-DR. During external test, pad drive values come from latch bits [2N-1:N] and pad enables from latch bits [3N-1:2N].
- R8: While the high-impedance request is high, every pad enable is 0, except while external test is active.
- R9: With sample/preload active, pad drive and enable follow the core outputs and enables even while the boundary register captures, shifts and updates.
- R10: Serial out and its enable change on the falling test clock. The enable is 1 only in Shift-IR and Shift-DR. When the enable is 0, serial out reads 0.
- R11: The core-side input vector follows the pad inputs, except during external test, when it takes update latch bits [N-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| core_out | input | NCELLS | Core drive values for the pads |
| core_oe | input | NCELLS | Core output enables for the pads |
| pad_in | input | NCELLS | Values received at the pads |
| glob_hiz | input | 1 | Chip-wide high-impedance request |
| pad_out | output | NCELLS | Final pad drive values |
| pad_oe | output | NCELLS | Final pad output enables |
| core_in | output | NCELLS | Pad input values presented to the core |

## Verification
The bench builds the block with NCELLS set to 4. The boundary chain is then 12 bits long, so a single scan both fills every cell and pulls out every captured cell, which makes the capture field positions, the update-only-on-Update-DR rule and the external-test overrides checkable bit by bit. A long random walk of the mode select, with random pad and core values, drives the controller through every state and every abort path (Pause, Exit2, early Select-IR to Test-Logic-Reset), and the behavioural model is checked against the design's outputs at each of those cycles.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET  = 4'd0,
    ST_IDLE   = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_t;

  typedef enum logic [1:0] {
    SEL_BYPASS = 2'd0,
    SEL_SAMPLE = 2'd1,
    SEL_EXTEST = 2'd2
  } op_sel_t;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b001;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= nxt;
  end

  assert_reset_holds_R1: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_RESET && tms) |=> state == ST_RESET);

  assert_shift_dr_stays_R2: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_SH_DR && !tms) |=> state == ST_SH_DR);

  assert_update_ir_exit_R2: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_UPD_IR) |=> (state == ST_SEL_DR || state == ST_IDLE));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tdi,
  input  tap_state_t state,
  output logic       ir_so,
  output op_sel_t    op
);

  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_cur;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sh  <= IR_CAPTURE;
      ir_cur <= OP_BYPASS;
    end else begin
      case (state)
        ST_RESET:  ir_cur <= OP_BYPASS;
        ST_CAP_IR: ir_sh  <= IR_CAPTURE;
        ST_SH_IR:  ir_sh  <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: ir_cur <= ir_sh;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (ir_cur)
      OP_EXTEST: op = SEL_EXTEST;
      OP_SAMPLE: op = SEL_SAMPLE;
      default:   op = SEL_BYPASS;
    endcase
  end

  assign ir_so = ir_sh[0];

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_IR) |=> ir_sh == IR_CAPTURE);

  assert_ir_update_only_R4: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(ir_cur) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET));

  assert_reset_bypass_R1: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_RESET) |=> op == SEL_BYPASS);

endmodule

// File: rtl/scan_tap_bsr.sv
module scan_tap_bsr
  import scan_tap_pkg::*;
#(
  parameter int NCELLS = 8
) (
  input  logic              tck,
  input  logic              por_n,
  input  logic              tdi,
  input  tap_state_t        state,
  input  logic              active,
  input  logic [NCELLS-1:0] pad_in,
  input  logic [NCELLS-1:0] core_out,
  input  logic [NCELLS-1:0] core_oe,
  output logic              bs_so,
  output logic [NCELLS-1:0] upd_in,
  output logic [NCELLS-1:0] upd_out,
  output logic [NCELLS-1:0] upd_oe
);

  localparam int LEN = 3 * NCELLS;

  logic [LEN-1:0] sh;
  logic [LEN-1:0] upd;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      sh  <= '0;
      upd <= '0;
    end else if (active) begin
      case (state)
        ST_CAP_DR: sh  <= {core_oe, core_out, pad_in};
        ST_SH_DR:  sh  <= {tdi, sh[LEN-1:1]};
        ST_UPD_DR: upd <= sh;
        default:   ;
      endcase
    end
  end

  assign bs_so   = sh[0];
  assign upd_in  = upd[NCELLS-1:0];
  assign upd_out = upd[2*NCELLS-1:NCELLS];
  assign upd_oe  = upd[LEN-1:2*NCELLS];

  assert_capture_fields_R6: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_DR && active) |=> sh == $past({core_oe, core_out, pad_in}));

  assert_latch_update_only_R7: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(upd) |-> $past(state) == ST_UPD_DR);

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
#(
  parameter int NCELLS = 8
) (
  input  logic              tck,
  input  logic              por_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic [NCELLS-1:0] core_out,
  input  logic [NCELLS-1:0] core_oe,
  input  logic [NCELLS-1:0] pad_in,
  input  logic              glob_hiz,
  output logic [NCELLS-1:0] pad_out,
  output logic [NCELLS-1:0] pad_oe,
  output logic [NCELLS-1:0] core_in
);

  tap_state_t        state;
  op_sel_t           op;
  logic              ir_so;
  logic              bs_so;
  logic              byp_q;
  logic              ext;
  logic              bs_active;
  logic [NCELLS-1:0] upd_in;
  logic [NCELLS-1:0] upd_out;
  logic [NCELLS-1:0] upd_oe;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .por_n (por_n),
    .tms   (tms),
    .state (state)
  );

  scan_tap_ir u_ir (
    .tck   (tck),
    .por_n (por_n),
    .tdi   (tdi),
    .state (state),
    .ir_so (ir_so),
    .op    (op)
  );

  assign ext       = (op == SEL_EXTEST);
  assign bs_active = (op != SEL_BYPASS);

  scan_tap_bsr #(.NCELLS(NCELLS)) u_bsr (
    .tck      (tck),
    .por_n    (por_n),
    .tdi      (tdi),
    .state    (state),
    .active   (bs_active),
    .pad_in   (pad_in),
    .core_out (core_out),
    .core_oe  (core_oe),
    .bs_so    (bs_so),
    .upd_in   (upd_in),
    .upd_out  (upd_out),
    .upd_oe   (upd_oe)
  );

  // Single-flop bypass path
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) byp_q <= 1'b0;
    else if (op == SEL_BYPASS) begin
      if (state == ST_CAP_DR)     byp_q <= 1'b0;
      else if (state == ST_SH_DR) byp_q <= tdi;
    end
  end

  // Serial out retimed to the falling edge
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else if (state == ST_SH_IR) begin
      tdo    <= ir_so;
      tdo_en <= 1'b1;
    end else if (state == ST_SH_DR) begin
      tdo    <= bs_active ? bs_so : byp_q;
      tdo_en <= 1'b1;
    end else begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCELLS; i++) begin : g_pad
    assign pad_out[i] = ext ? upd_out[i] : core_out[i];
    assign pad_oe[i]  = ext ? upd_oe[i]  : (core_oe[i] & ~glob_hiz);
    assign core_in[i] = ext ? upd_in[i]  : pad_in[i];
  end

  assert_bypass_clear_R5: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_DR && op == SEL_BYPASS) |=> byp_q == 1'b0);

  assert_hiz_off_R8: assert property (@(posedge tck) disable iff (!por_n)
    (glob_hiz && op != SEL_EXTEST) |-> pad_oe == '0);

  assert_sample_core_R9: assert property (@(posedge tck) disable iff (!por_n)
    (op == SEL_SAMPLE) |-> (pad_out == core_out && pad_oe == (core_oe & ~{NCELLS{glob_hiz}})));

  assert_tdo_quiet_R10: assert property (@(posedge tck) disable iff (!por_n)
    !tdo_en |-> !tdo);

endmodule

// File: tb/scan_tap_ctrl_tb.sv
module scan_tap_ctrl_tb_top;

  localparam int N = 4;
  localparam int L = 3 * N;

  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHD = 4, S_E1D = 5,
                 S_PD = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHI = 11,
                 S_E1I = 12, S_PI = 13, S_E2I = 14, S_UIR = 15;

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0, glob_hiz = 1'b0;
  logic tdo, tdo_en;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, core_in;

  scan_tap_ctrl #(.NCELLS(N)) dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in), .glob_hiz(glob_hiz),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
  );

  always #10 tck = ~tck;

  int nvec = 0, nfail = 0;
  string cur_req = "R1";
  bit rnd_io = 1'b0;

  int mst = S_TLR;
  logic [2:0] mir_sh = 3'b001, mir_cur = 3'b111;
  logic mbyp = 1'b0, mtdo = 1'b0, mtdoen = 1'b0;
  logic [L-1:0] mbs = '0, mupd = '0;

  function automatic int next_of(int s, bit t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;
      S_RTI: return t ? S_SDR : S_RTI;
      S_SDR: return t ? S_SIR : S_CDR;
      S_CDR, S_SHD: return t ? S_E1D : S_SHD;
      S_E1D: return t ? S_UDR : S_PD;
      S_PD:  return t ? S_E2D : S_PD;
      S_E2D: return t ? S_UDR : S_SHD;
      S_SIR: return t ? S_TLR : S_CIR;
      S_CIR, S_SHI: return t ? S_E1I : S_SHI;
      S_E1I: return t ? S_UIR : S_PI;
      S_PI:  return t ? S_E2I : S_PI;
      S_E2I: return t ? S_UIR : S_SHI;
      default: return t ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic bit m_scan();
    return (mir_cur == 3'b000) || (mir_cur == 3'b001);
  endfunction

  task automatic model_rise(bit t, bit d);
    if (mst == S_TLR) mir_cur = 3'b111;
    if (mst == S_CIR) mir_sh = 3'b001;
    if (mst == S_SHI) mir_sh = {d, mir_sh[2:1]};
    if (mst == S_UIR) mir_cur = mir_sh;
    if (!m_scan()) begin
      if (mst == S_CDR) mbyp = 1'b0;
      if (mst == S_SHD) mbyp = d;
    end else begin
      if (mst == S_CDR)
        for (int i = 0; i < N; i++) begin
          mbs[i] = pad_in[i]; mbs[N+i] = core_out[i]; mbs[2*N+i] = core_oe[i];
        end
      if (mst == S_SHD) begin
        for (int i = 0; i < L - 1; i++) mbs[i] = mbs[i+1];
        mbs[L-1] = d;
      end
      if (mst == S_UDR) mupd = mbs;
    end
    mst = next_of(mst, t);
  endtask

  task automatic model_fall();
    mtdoen = (mst == S_SHI) || (mst == S_SHD);
    if (mst == S_SHI) mtdo = mir_sh[0];
    else if (mst == S_SHD) mtdo = m_scan() ? mbs[0] : mbyp;
    else mtdo = 1'b0;
  endtask

  task automatic cmp();
    logic [N-1:0] e_po, e_oe, e_ci;
    bit ext = (mir_cur == 3'b000);
    for (int i = 0; i < N; i++) begin
      e_po[i] = ext ? mupd[N+i]   : core_out[i];
      e_oe[i] = ext ? mupd[2*N+i] : (core_oe[i] & ~glob_hiz);
      e_ci[i] = ext ? mupd[i]     : pad_in[i];
    end
    nvec++;
    if (tdo !== mtdo || tdo_en !== mtdoen || pad_out !== e_po || pad_oe !== e_oe || core_in !== e_ci) begin
      nfail++;
      $display("FAIL %s: tdo=%b/%b tdo_en=%b/%b pad_out=%h/%h pad_oe=%h/%h core_in=%h/%h (actual/expected)",
               cur_req, tdo, mtdo, tdo_en, mtdoen, pad_out, e_po, pad_oe, e_oe, core_in, e_ci);
    end
  endtask

  task automatic tick(bit t, bit d);
    tms = t; tdi = d;
    if (rnd_io) begin
      core_out = N'($urandom); core_oe = N'($urandom);
      pad_in = N'($urandom); glob_hiz = 1'($urandom);
    end
    @(posedge tck);
    model_rise(t, d);
    @(negedge tck);
    model_fall();
    #3;
    cmp();
  endtask

  task automatic to_reset();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic load_ir(logic [2:0] code);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) tick(i == 2, code[i]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(int n, logic [63:0] data);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) tick(i == n - 1, data[i]);
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    // R1: power-on state
    #25; cur_req = "R1"; cmp();
    @(negedge tck); #2; por_n = 1'b1;
    tick(0, 0); tick(1, 0); tick(0, 0);
    to_reset();
    cur_req = "R5"; scan_dr(6, 64'b101101);
    // R3: captured IR pattern, then external test
    cur_req = "R3"; load_ir(3'b000);
    core_out = 4'h5; core_oe = 4'hC; pad_in = 4'h9;
    cur_req = "R6"; scan_dr(L, 64'h3A6);
    cur_req = "R7"; scan_dr(L, 64'hF0F);
    cur_req = "R11"; pad_in = 4'h6; tick(0, 0); pad_in = 4'h1; tick(0, 0);
    cur_req = "R8"; glob_hiz = 1'b1; tick(0, 0); tick(0, 0);
    cur_req = "R4"; load_ir(3'b111); tick(0, 0);
    glob_hiz = 1'b0; core_oe = 4'hF; tick(0, 0);
    cur_req = "R9"; load_ir(3'b001); glob_hiz = 1'b1; scan_dr(L, 64'h5A5);
    glob_hiz = 1'b0; scan_dr(L, 64'h0C3);
    cur_req = "R4"; load_ir(3'b101); scan_dr(5, 64'b10011);
    load_ir(3'b010); scan_dr(4, 64'b0111);
    cur_req = "R1"; load_ir(3'b000); to_reset(); scan_dr(3, 64'b110);
    // R2 / R10: random walk through the whole state graph
    cur_req = "R2"; rnd_io = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      if (k == 1500) cur_req = "R10";
      if (k % 400 == 0) load_ir(k % 800 == 0 ? 3'b000 : 3'b001);
      tick(1'($urandom_range(0, 99) < 40), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule